// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it receives two byte operands, an operation code and a bit index. It returns a byte result, together with a flag that says whether that result should be written back. It also holds an eight-bit status register. Every operation updates only the flags it is defined to touch, and every other flag keeps its stored value.

The result path is combinational. It uses the operands and the status bits that are stored at that moment, including the carry. The status register loads on the rising clock edge when `op_valid` is high. The incoming carry and the T bit are always taken from the stored status, so chained operations such as multi-byte additions and comparisons work without any extra wiring.

Status bit positions, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. S is always N XOR V. H is the carry out of bit 3 for additions and the borrow into bit 4 for subtractions.

Top module: `alu8_status`

## Requirements
- R1: A synchronous reset with `rst` high clears the status register to 0x00.
- R2: Add (op 0) and add-with-carry (op 1, adding stored C) give a+b(+C) mod 256 with `result_we` high. They update C (carry out of bit 7), H, V (signed overflow), N (result bit 7), Z (result zero) and S.
- R3: Subtract (op 2) and subtract-with-carry (op 3, subtracting stored C) give a-b(-C) mod 256 with `result_we` high. C is the borrow, and H, V, N and S follow the result. Op 3 can only keep Z or clear it: Z becomes 1 only if it was already 1 and the result is zero.
- R4: Compare (op 4) and compare-with-carry (op 5) set the flags exactly as ops 2 and 3 do, but hold `result_we` low.
- R5: AND (op 6), OR (op 7) and XOR (op 8) update only Z, N, V and S, and force V to 0.
- R6: One's complement (op 9) gives 0xFF-a, sets C to 1 and V to 0, and updates Z, N and S. Two's complement (op 10) gives 0x00-a, with C=1 when the result is nonzero, V=1 when the result is 0x80, and H set by the borrow into bit 4. It also updates Z, N and S.
- R7: Increment (op 11) and decrement (op 12) update only Z, N, V and S, and leave C and H unchanged. V is 1 when increment gives 0x80 or decrement gives 0x7F.
- R8: The shifts and rotates update C, Z, N, V and S, with V = N XOR C:
  - op 13 shifts left with a 0 in, and C takes bit 7.
  - op 14 shifts right with a 0 in, and C takes bit 0.
  - op 15 shifts right and keeps bit 7, and C takes bit 0.
  - op 16 rotates left with the old C into bit 0, and C takes bit 7.
  - op 17 rotates right with the old C into bit 7, and C takes bit 0.
- R9: Nibble swap (op 18) exchanges bits 7:4 and 3:0 of a, with `result_we` high, and changes no flag.
- R10: Flag set (op 19) and flag clear (op 20) force the status bit at index `bit_sel` to 1 or 0. They leave the other seven bits alone and hold `result_we` low.
- R11: Bit store (op 21) copies a[`bit_sel`] into T, with `result_we` low. Bit load (op 22) outputs a with bit `bit_sel` replaced by T, with `result_we` high, and changes no flag.
- R12: After any operation that updates N or V, the stored S equals N XOR V.
- R13: While `op_valid` is low, `result_we` is low and the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code (see requirements) |
| opnd_a | input | 8 | Destination-side operand |
| opnd_b | input | 8 | Source-side operand |
| bit_sel | input | 3 | Bit index for flag and bit operations |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result should be written back |
| status | output | 8 | Stored status register |

## Verification
The assertions check on every cycle the rules that hold for whole groups of operations:
- S agrees with N XOR V after arithmetic, logical and shift operations.
- Compare, flag and bit-store operations never raise the write enable.
- Swap and an idle cycle leave the status untouched.
- Increment and decrement keep the carry.
- A with-carry subtract or compare never newly sets Z.

The exact result values and the flag values at the edges can only be shown by the bench's scenarios. These cover:
- signed overflow at 0x7F/0x80
- wrap-around to zero
- negating 0x80
- the carry that threads through the rotates
- a multi-byte compare in which Z stays set and then clears

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int SW  = 8;
    localparam int OPW = 5;
    localparam int BSW = $clog2(DW);
    localparam int NIB = DW / 2;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,  OP_CPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ASR  = 5'd15,
        OP_ROL  = 5'd16, OP_ROR  = 5'd17, OP_SWAP = 5'd18, OP_FSET = 5'd19,
        OP_FCLR = 5'd20, OP_BST  = 5'd21, OP_BLD  = 5'd22
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          h;
        logic          v;
    } arith_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          we;
        logic [SW-1:0] flags;
        logic [SW-1:0] mask;
    } alu_out_t;

    function automatic arith_t add_fn(logic [DW-1:0] a, logic [DW-1:0] b, logic cin);
        arith_t      r;
        logic [DW:0] s;
        s     = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        r.res = s[DW-1:0];
        r.c   = s[DW];
        r.h   = (a[NIB-1] & b[NIB-1]) | (b[NIB-1] & ~s[NIB-1]) | (~s[NIB-1] & a[NIB-1]);
        r.v   = (a[DW-1] & b[DW-1] & ~s[DW-1]) | (~a[DW-1] & ~b[DW-1] & s[DW-1]);
        return r;
    endfunction

    function automatic arith_t sub_fn(logic [DW-1:0] a, logic [DW-1:0] b, logic bin);
        arith_t      r;
        logic [DW:0] d;
        d     = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
        r.res = d[DW-1:0];
        r.c   = d[DW];
        r.h   = (~a[NIB-1] & b[NIB-1]) | (b[NIB-1] & d[NIB-1]) | (d[NIB-1] & ~a[NIB-1]);
        r.v   = (a[DW-1] & ~b[DW-1] & ~d[DW-1]) | (~a[DW-1] & b[DW-1] & d[DW-1]);
        return r;
    endfunction

    function automatic logic [SW-1:0] fmask(logic c, logic z, logic n, logic v, logic h);
        logic [SW-1:0] m;
        m       = '0;
        m[FL_C] = c;
        m[FL_Z] = z;
        m[FL_N] = n;
        m[FL_V] = v;
        m[FL_S] = n | v;
        m[FL_H] = h;
        return m;
    endfunction

endpackage

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [BSW-1:0] sel,
    input  logic [SW-1:0]  st,
    output alu_out_t       out
);

    arith_t        ar;
    logic [DW-1:0] res;
    logic          we, c, h, v, z_sticky;
    logic [SW-1:0] mask;
    logic          n, z;

    always_comb begin
        ar       = '0;
        res      = a;
        we       = 1'b0;
        c        = st[FL_C];
        h        = st[FL_H];
        v        = st[FL_V];
        z_sticky = 1'b0;
        mask     = '0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                ar   = add_fn(a, b, (op == OP_ADC) & st[FL_C]);
                res  = ar.res; c = ar.c; h = ar.h; v = ar.v; we = 1'b1;
                mask = fmask(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
            end
            OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
                ar       = sub_fn(a, b, ((op == OP_SBC) || (op == OP_CPC)) & st[FL_C]);
                res      = ar.res; c = ar.c; h = ar.h; v = ar.v;
                we       = (op == OP_SUB) || (op == OP_SBC);
                z_sticky = (op == OP_SBC) || (op == OP_CPC);
                mask     = fmask(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
            end
            OP_AND, OP_OR, OP_XOR: begin
                res  = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
                v    = 1'b0; we = 1'b1;
                mask = fmask(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
            end
            OP_COM: begin
                res  = ~a; c = 1'b1; v = 1'b0; we = 1'b1;
                mask = fmask(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            end
            OP_NEG: begin
                ar   = sub_fn('0, a, 1'b0);
                res  = ar.res; c = ar.c; h = ar.h; v = ar.v; we = 1'b1;
                mask = fmask(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
            end
            OP_INC, OP_DEC: begin
                ar   = (op == OP_INC) ? add_fn(a, '0, 1'b1) : sub_fn(a, '0, 1'b1);
                res  = ar.res; v = ar.v; we = 1'b1;
                mask = fmask(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
            end
            OP_LSL, OP_ROL: begin
                res  = {a[DW-2:0], (op == OP_ROL) & st[FL_C]};
                c    = a[DW-1]; v = res[DW-1] ^ a[DW-1]; we = 1'b1;
                mask = fmask(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            end
            OP_LSR, OP_ASR, OP_ROR: begin
                res  = {(op == OP_ASR) ? a[DW-1] : ((op == OP_ROR) & st[FL_C]), a[DW-1:1]};
                c    = a[0]; v = res[DW-1] ^ a[0]; we = 1'b1;
                mask = fmask(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            end
            OP_SWAP: begin
                res = {a[NIB-1:0], a[DW-1:NIB]}; we = 1'b1;
            end
            OP_FSET, OP_FCLR, OP_BST: begin
                mask      = '0;
                mask[sel] = 1'b1;
                if (op == OP_BST) begin
                    mask      = '0;
                    mask[FL_T] = 1'b1;
                end
            end
            OP_BLD: begin
                res      = a;
                res[sel] = st[FL_T];
                we       = 1'b1;
            end
            default: ;
        endcase
    end

    assign n = res[DW-1];
    assign z = (res == '0) & (~z_sticky | st[FL_Z]);

    always_comb begin
        out.res   = res;
        out.we    = we;
        out.mask  = mask;
        out.flags = st;
        if (op == OP_FSET || op == OP_FCLR) begin
            out.flags[sel] = (op == OP_FSET);
        end else if (op == OP_BST) begin
            out.flags[FL_T] = a[sel];
        end else begin
            out.flags[FL_C] = c;
            out.flags[FL_Z] = z;
            out.flags[FL_N] = n;
            out.flags[FL_V] = v;
            out.flags[FL_S] = n ^ v;
            out.flags[FL_H] = h;
        end
    end

    always_comb begin
        if (op == OP_CMP || op == OP_CPC || op == OP_FSET || op == OP_FCLR || op == OP_BST)
            AST_NO_WB_FOR_FLAG_OPS: assert (!we); // R4
    end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [SW-1:0] flags_in,
    input  logic [SW-1:0] mask_in,
    output logic [SW-1:0] st_q
);

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (upd)
            st_q <= (st_q & ~mask_in) | (flags_in & mask_in);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> st_q == '0); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !upd |=> st_q == $past(st_q)); // R13

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [4:0]  op,
    input  logic [7:0]  opnd_a,
    input  logic [7:0]  opnd_b,
    input  logic [2:0]  bit_sel,
    output logic [7:0]  result,
    output logic        result_we,
    output logic [7:0]  status
);

    alu_out_t      core_o;
    logic [SW-1:0] st_q;
    alu_op_e       op_e;

    assign op_e = alu_op_e'(op);

    alu8_core u_core (
        .op  (op_e),
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (bit_sel),
        .st  (st_q),
        .out (core_o)
    );

    alu8_flagreg u_flags (
        .clk      (clk),
        .rst      (rst),
        .upd      (op_valid),
        .flags_in (core_o.flags),
        .mask_in  (core_o.mask),
        .st_q     (st_q)
    );

    assign result    = core_o.res;
    assign result_we = op_valid & core_o.we;
    assign status    = st_q;

    AST_SIGN_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op <= 5'd17) |=> status[FL_S] == (status[FL_N] ^ status[FL_V])); // R12
    AST_SWAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == 5'd18) |=> status == $past(status)); // R9
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == 5'd11 || op == 5'd12)) |=> status[FL_C] == $past(status[FL_C])); // R7
    AST_CARRY_Z_STICKY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == 5'd3 || op == 5'd5) && !status[FL_Z]) |=> !status[FL_Z]); // R3
    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !result_we); // R13

endmodule

// File: tb/alu8_status_tb.sv
`timescale 1ns/1ps
module alu8_status_tb_top;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [4:0] op;
    logic [7:0] opnd_a, opnd_b;
    logic [2:0] bit_sel;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    alu8_status dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel),
        .result(result), .result_we(result_we), .status(status)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(string tag, alu_op_e o, logic [7:0] a, logic [7:0] b,
                          logic [2:0] sel, logic [7:0] exp_res, logic exp_we,
                          logic [7:0] exp_st);
        @(negedge clk);
        op_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; bit_sel = sel;
        #1;
        chk({tag, " we"}, int'(result_we), int'(exp_we));
        if (exp_we) chk({tag, " result"}, int'(result), int'(exp_res));
        @(posedge clk);
        #1;
        chk({tag, " status"}, int'(status), int'(exp_st));
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; op_valid = 1'b0; op = '0; opnd_a = '0; opnd_b = '0; bit_sel = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", int'(status), 0);
        chk("R13 idle we", int'(result_we), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_flags();
        run_op("R10 set I", OP_FSET, 8'h00, 8'h00, 3'd7, 8'h00, 1'b0, 8'h80);
        run_op("R10 clear I", OP_FCLR, 8'h00, 8'h00, 3'd7, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_add();
        run_op("R2 add overflow", OP_ADD, 8'h7F, 8'h01, 3'd0, 8'h80, 1'b1, 8'h2C);
        run_op("R2 add wrap", OP_ADD, 8'hFF, 8'h01, 3'd0, 8'h00, 1'b1, 8'h23);
        run_op("R2 adc carry in", OP_ADC, 8'h10, 8'h20, 3'd0, 8'h31, 1'b1, 8'h00);
    endtask

    task automatic t_sub();
        run_op("R3 sub borrow", OP_SUB, 8'h00, 8'h01, 3'd0, 8'hFF, 1'b1, 8'h35);
        run_op("R4 cmp equal", OP_CMP, 8'h05, 8'h05, 3'd0, 8'h00, 1'b0, 8'h02);
        run_op("R4 cpc keep Z", OP_CPC, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 8'h02);
        run_op("R4 cpc clear Z", OP_CPC, 8'h01, 8'h00, 3'd0, 8'h00, 1'b0, 8'h00);
        run_op("R4 cpc no new Z", OP_CPC, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 8'h00);
        run_op("R10 set C", OP_FSET, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 8'h01);
        run_op("R3 sbc sticky Z", OP_SBC, 8'h05, 8'h04, 3'd0, 8'h00, 1'b1, 8'h00);
    endtask

    task automatic t_logic();
        run_op("R10 set C", OP_FSET, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 8'h01);
        run_op("R10 set H", OP_FSET, 8'h00, 8'h00, 3'd5, 8'h00, 1'b0, 8'h21);
        run_op("R5 and", OP_AND, 8'hF0, 8'h3C, 3'd0, 8'h30, 1'b1, 8'h21);
        run_op("R5 xor neg", OP_XOR, 8'h80, 8'h00, 3'd0, 8'h80, 1'b1, 8'h35);
        run_op("R5 or zero", OP_OR, 8'h00, 8'h00, 3'd0, 8'h00, 1'b1, 8'h23);
    endtask

    task automatic t_unary();
        run_op("R6 com", OP_COM, 8'h55, 8'h00, 3'd0, 8'hAA, 1'b1, 8'h35);
        run_op("R6 neg 0x80", OP_NEG, 8'h80, 8'h00, 3'd0, 8'h80, 1'b1, 8'h0D);
        run_op("R6 neg zero", OP_NEG, 8'h00, 8'h00, 3'd0, 8'h00, 1'b1, 8'h02);
        run_op("R10 set C", OP_FSET, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 8'h03);
        run_op("R7 inc overflow", OP_INC, 8'h7F, 8'h00, 3'd0, 8'h80, 1'b1, 8'h0D);
        run_op("R7 dec overflow", OP_DEC, 8'h80, 8'h00, 3'd0, 8'h7F, 1'b1, 8'h19);
        run_op("R7 dec zero", OP_DEC, 8'h01, 8'h00, 3'd0, 8'h00, 1'b1, 8'h03);
    endtask

    task automatic t_shift();
        run_op("R8 lsl", OP_LSL, 8'h81, 8'h00, 3'd0, 8'h02, 1'b1, 8'h19);
        run_op("R8 lsr", OP_LSR, 8'h01, 8'h00, 3'd0, 8'h00, 1'b1, 8'h1B);
        run_op("R8 ror", OP_ROR, 8'h02, 8'h00, 3'd0, 8'h81, 1'b1, 8'h0C);
        run_op("R8 rol", OP_ROL, 8'h80, 8'h00, 3'd0, 8'h00, 1'b1, 8'h1B);
        run_op("R8 asr", OP_ASR, 8'h81, 8'h00, 3'd0, 8'hC0, 1'b1, 8'h15);
        run_op("R9 swap", OP_SWAP, 8'h3C, 8'h00, 3'd0, 8'hC3, 1'b1, 8'h15);
    endtask

    task automatic t_bits();
        run_op("R11 bst one", OP_BST, 8'h10, 8'h00, 3'd4, 8'h00, 1'b0, 8'h55);
        run_op("R11 bld", OP_BLD, 8'h00, 8'h00, 3'd2, 8'h04, 1'b1, 8'h55);
        run_op("R11 bst zero", OP_BST, 8'h10, 8'h00, 3'd3, 8'h00, 1'b0, 8'h15);
        run_op("R11 bld clear", OP_BLD, 8'hFF, 8'h00, 3'd7, 8'h7F, 1'b1, 8'h15);
    endtask

    task automatic t_idle();
        @(negedge clk);
        op_valid = 1'b0; op = OP_ADD; opnd_a = 8'hFF; opnd_b = 8'h01;
        #1;
        chk("R13 idle we", int'(result_we), 0);
        @(posedge clk);
        #1;
        chk("R13 idle status", int'(status), 8'h15);
        run_op("R10 clear S", OP_FCLR, 8'h00, 8'h00, 3'd4, 8'h00, 1'b0, 8'h05);
        run_op("R12 sign after sub", OP_SUB, 8'h80, 8'h01, 3'd0, 8'h7F, 1'b1, 8'h38);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_flags();
                t_add();
                t_sub();
                t_logic();
                t_unary();
                t_shift();
                t_bits();
                t_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule